// File: doc/BRIEF.md
# PCM Highway Time-Slot Port

This block connects a voice path to a serial PCM highway. It runs on a fast system clock and oversamples the highway bit clock (`pclk_i`) and the frame sync (`fsync_i`). A frame starts at a bit-clock rising edge on which the frame sync is high. The block counts bit-clock rising edges from that edge. It shifts one transmit sample out and one receive sample in, each within its own slot.

The transmit slot and the receive slot each have a 10-bit start position, measured in bit-clock periods after the frame sync. The two positions are set independently. A mode input selects the sample width: 8 bits for either companded law, or 16 bits for linear and wideband samples. The companding itself is done elsewhere. Outside its slot, and whenever the port is disabled, the transmit pad enable is low so the line floats. The transmit word is taken from a parallel input at the frame sync edge. Each received word is presented on a parallel output with a single-cycle strobe.

Top module: `pcm_slot_port`

## Requirements
- R1: The rising bit-clock edge on which `fsync_i` is high has count 0, and each later rising edge adds one. Before the first frame sync after reset, no slot is active.
- R2: The transmit slot covers the counts `tx_start_i` to `tx_start_i`+W-1, where W is the sample width. `dtx_oe_o` is high during exactly those counts and low at all other times.
- R3: The receive slot covers `rx_start_i` to `rx_start_i`+W-1. It is placed independently of the transmit slot, and the two slots may overlap.
- R4: Transmit bits go out most significant bit first. `dtx_o` changes only on system clocks that see a bit-clock rising edge.
- R5: Each receive bit is taken from `drx_i` at the bit-clock falling edge that follows the rising edge of its count.
- R6: `mode_i` 00 (mu-law) and 01 (A-law) give W=8. The transmit word is then `tx_sample_i[7:0]`, and the received byte appears in `rx_sample_o[7:0]` with the upper byte zero. `mode_i` 10 (linear) and 11 (wideband) give W=16 and use all 16 bits.
- R7: `rx_valid_o` pulses high for exactly one system clock after the last bit of a receive slot is captured. `rx_sample_o` changes only together with that pulse.
- R8: While `en_i` is low, `dtx_oe_o` falls within one system clock and no receive word is delivered. A receive slot that is cut by a disable is discarded.
- R9: A slot whose start plus W exceeds `FRAME_PCLKS` causes no transfer in that frame.
- R10: The transmit word is captured at the frame sync edge. Changes on `tx_sample_i` later in the frame do not affect the bits sent.
- R11: After reset, `dtx_oe_o`, `rx_valid_o` and `rx_sample_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pclk_i | input | 1 | Highway bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync, sampled at bit-clock rising edges |
| en_i | input | 1 | Port enable |
| mode_i | input | 2 | Sample format: 00 mu-law, 01 A-law, 10 linear, 11 wideband |
| tx_start_i | input | 10 | Transmit slot start count |
| rx_start_i | input | 10 | Receive slot start count |
| tx_sample_i | input | 16 | Parallel transmit word |
| drx_i | input | 1 | Serial receive data |
| dtx_o | output | 1 | Serial transmit data |
| dtx_oe_o | output | 1 | Transmit pad enable; line floats when low |
| rx_sample_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |

## Verification
Some rules are checked by assertions on every cycle:
- `dtx_o` moves only on bit-clock rising edges.
- The pad enable falls after a disable.
- The frame count steps by one per edge.
- The receive strobe lasts one cycle, follows a falling edge, and is the only time the received word changes.

Other behaviour can only be shown by the bench's scenarios. This covers where each slot lands and how wide it is, the bit order, and the independent receive position. It also covers the overrun rule at the frame boundary, the capture of the transmit word at frame sync, and the loss of a receive word cut by a disable.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic [1:0] {
    MODE_ULAW   = 2'b00,
    MODE_ALAW   = 2'b01,
    MODE_LIN16  = 2'b10,
    MODE_WIDE16 = 2'b11
  } pcm_mode_e;

  function automatic logic mode_is_wide(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pcm_frame_cnt.sv
module pcm_frame_cnt #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          fsync_i,
  output logic          rise_o,
  output logic          fall_o,
  output logic [CW-1:0] cnt_now_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic pclk_q;

  assign rise_o    = pclk_i & ~pclk_q;
  assign fall_o    = ~pclk_i & pclk_q;
  // count belonging to the rising edge seen this cycle
  assign cnt_now_o = fsync_i ? '0 : ((cnt_o == CMAX) ? CMAX : cnt_o + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      cnt_o  <= CMAX;
    end else begin
      pclk_q <= pclk_i;
      if (rise_o) cnt_o <= cnt_now_o;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !fsync_i && cnt_o != CMAX) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
  AST_CNT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && fsync_i) |=> (cnt_o == '0)); // R1
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int CW          = 11,
  parameter int SW          = 10,
  parameter int DW          = 16,
  parameter int FRAME_PCLKS = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fsync_i,
  input  logic [CW-1:0] cnt_now_i,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic [SW-1:0] start_i,
  input  logic [DW-1:0] sample_i,
  output logic          dtx_o,
  output logic          oe_o
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);

  logic [DW-1:0] buf_q, src_c, aligned_c;
  logic [CW-1:0] width_c, end_c, idx_c;
  logic          fits_c, in_win_c, bit_c;

  assign width_c   = wide_i ? CW'(DW) : CW'(HW);
  assign end_c     = CW'(start_i) + width_c;
  assign fits_c    = end_c <= CW'(FRAME_PCLKS);
  assign in_win_c  = fits_c && (cnt_now_i >= CW'(start_i)) && (cnt_now_i < end_c);
  assign idx_c     = cnt_now_i - CW'(start_i);
  // word for the slot: live input on the sync edge, held copy afterwards
  assign src_c     = fsync_i ? sample_i : buf_q;
  assign aligned_c = wide_i ? src_c : {src_c[HW-1:0], {HW{1'b0}}};
  assign bit_c     = aligned_c[IW'(DW-1) - idx_c[IW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      dtx_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      if (rise_i && fsync_i) buf_q <= sample_i;
      if (!en_i) begin
        oe_o <= 1'b0;
      end else if (rise_i) begin
        oe_o  <= in_win_c;
        dtx_o <= in_win_c ? bit_c : 1'b0;
      end
    end
  end

  AST_TX_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(dtx_o)); // R4
  AST_TX_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !oe_o); // R8
  AST_TX_OE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && en_i) |=> $stable(oe_o)); // R2
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int CW          = 11,
  parameter int SW          = 10,
  parameter int DW          = 16,
  parameter int FRAME_PCLKS = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic [SW-1:0] start_i,
  input  logic          drx_i,
  output logic [DW-1:0] sample_o,
  output logic          valid_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] shift_q;
  logic [CW-1:0] width_c, end_c, idx_c;
  logic          fits_c, in_win_c, first_c, last_c, good_q;

  assign width_c  = wide_i ? CW'(DW) : CW'(HW);
  assign end_c    = CW'(start_i) + width_c;
  assign fits_c   = end_c <= CW'(FRAME_PCLKS);
  assign in_win_c = fits_c && (cnt_i >= CW'(start_i)) && (cnt_i < end_c);
  assign idx_c    = cnt_i - CW'(start_i);
  assign first_c  = idx_c == '0;
  assign last_c   = idx_c == width_c - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
      good_q   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        good_q <= 1'b0;
      end else if (fall_i && in_win_c) begin
        shift_q <= {shift_q[DW-2:0], drx_i};
        if (first_c) good_q <= 1'b1;
        // a slot interrupted by a disable never gets first_c back, so it is dropped
        if (last_c && (good_q || first_c)) begin
          sample_o <= wide_i ? {shift_q[DW-2:0], drx_i}
                             : {{HW{1'b0}}, shift_q[HW-2:0], drx_i};
          valid_o  <= 1'b1;
          good_q   <= 1'b0;
        end
      end
    end
  end

  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_RX_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fall_i)); // R5
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R7
  AST_RX_NONE_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !valid_o); // R8
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int FRAME_PCLKS = 256,
  parameter int SW          = 10,
  parameter int DW          = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          fsync_i,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [SW-1:0] tx_start_i,
  input  logic [SW-1:0] rx_start_i,
  input  logic [DW-1:0] tx_sample_i,
  input  logic          drx_i,
  output logic          dtx_o,
  output logic          dtx_oe_o,
  output logic [DW-1:0] rx_sample_o,
  output logic          rx_valid_o
);
  import pcm_slot_pkg::*;

  localparam int CW = SW + 1;

  logic          rise, fall, wide;
  logic [CW-1:0] cnt_now, cnt;

  assign wide = mode_is_wide(mode_i);

  pcm_frame_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .pclk_i, .fsync_i,
    .rise_o(rise), .fall_o(fall), .cnt_now_o(cnt_now), .cnt_o(cnt)
  );

  pcm_tx_slot #(.CW(CW), .SW(SW), .DW(DW), .FRAME_PCLKS(FRAME_PCLKS)) u_tx (
    .clk_i, .rst_ni, .rise_i(rise), .fsync_i, .cnt_now_i(cnt_now), .en_i,
    .wide_i(wide), .start_i(tx_start_i), .sample_i(tx_sample_i),
    .dtx_o, .oe_o(dtx_oe_o)
  );

  pcm_rx_slot #(.CW(CW), .SW(SW), .DW(DW), .FRAME_PCLKS(FRAME_PCLKS)) u_rx (
    .clk_i, .rst_ni, .fall_i(fall), .cnt_i(cnt), .en_i, .wide_i(wide),
    .start_i(rx_start_i), .drx_i, .sample_o(rx_sample_o), .valid_o(rx_valid_o)
  );
endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  localparam int FR = 32;
  localparam int NV = 5;
  typedef logic [53:0] vec_t; // mode, tx start, rx start, tx word, rx word
  localparam vec_t VEC [NV] = '{
    {2'b00, 10'd0,  10'd5,  16'h00A5, 16'h003C},
    {2'b01, 10'd10, 10'd10, 16'h005A, 16'h00C3},
    {2'b10, 10'd3,  10'd16, 16'hBEEF, 16'h1234},
    {2'b11, 10'd16, 10'd0,  16'h8001, 16'hF00D},
    {2'b00, 10'd24, 10'd24, 16'hFF81, 16'h007E}
  };

  logic clk = 0, rst_n = 0, pclk = 0, fsync = 0, en = 0, drx = 0;
  logic [1:0] mode = 0;
  logic [9:0] txs = 0, rxs = 0;
  logic [15:0] txw = 0;
  logic dtx, oe, rvalid;
  logic [15:0] rsample;

  int nchecks = 0, nerr = 0;
  logic [FR-1:0] oe_rec, dtx_rec;
  int nvalid;
  logic [15:0] vsample;

  always #5 clk = ~clk;

  pcm_slot_port #(.FRAME_PCLKS(FR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .fsync_i(fsync), .en_i(en),
    .mode_i(mode), .tx_start_i(txs), .rx_start_i(rxs), .tx_sample_i(txw),
    .drx_i(drx), .dtx_o(dtx), .dtx_oe_o(oe), .rx_sample_o(rsample), .rx_valid_o(rvalid)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wid(input logic [1:0] m);
    return m[1] ? 16 : 8;
  endfunction

  function automatic logic [15:0] align(input logic [1:0] m, input logic [15:0] w);
    return m[1] ? w : {w[7:0], 8'h00};
  endfunction

  // one frame; fsync on count 0 when sync=1; en dropped from count drop_at
  task automatic run_frame(input logic [1:0] m, input logic [9:0] ts, input logic [9:0] rs,
                           input logic [15:0] tw, input logic [15:0] rw, input logic sync,
                           input int drop_at);
    logic [15:0] ra;
    ra = align(m, rw);
    mode = m; txs = ts; rxs = rs; txw = tw;
    oe_rec = '0; dtx_rec = '0; nvalid = 0; vsample = 'x;
    for (int c = 0; c < FR; c++) begin
      @(negedge clk);
      pclk = 1;
      fsync = sync && (c == 0);
      if (c == drop_at) en = 0;
      drx = (c >= int'(rs) && c < int'(rs) + wid(m)) ? ra[15 - (c - int'(rs))] : 1'b0;
      @(negedge clk);
      fsync = 0;
      txw = ~tw; // R10: later changes must not reach the line
      @(negedge clk);
      oe_rec[c] = oe; dtx_rec[c] = dtx;
      if (rvalid) begin nvalid++; vsample = rsample; end
      pclk = 0;
      @(negedge clk);
      if (rvalid) begin nvalid++; vsample = rsample; end
    end
  endtask

  task automatic check_frame(input logic [1:0] m, input logic [9:0] ts, input logic [9:0] rs,
                             input logic [15:0] tw, input logic [15:0] rw, input logic act);
    logic [FR-1:0] oe_exp;
    logic [15:0] bits, ta;
    int w;
    w = wid(m); ta = align(m, tw); bits = '0;
    for (int c = 0; c < FR; c++)
      oe_exp[c] = act && (int'(ts) + w <= FR) && c >= int'(ts) && c < int'(ts) + w;
    chk(oe_rec == oe_exp, "R2 tx slot window", oe_rec, oe_exp);
    if (oe_exp != '0) begin
      for (int k = 0; k < w; k++) bits[15 - k] = dtx_rec[int'(ts) + k];
      chk(bits == ta, "R4 R6 R10 tx bits msb first", bits, ta);
    end
    if (act && int'(rs) + w <= FR) begin
      chk(nvalid == 1, "R7 single rx strobe", nvalid, 1);
      chk(vsample == (m[1] ? rw : {8'h00, rw[7:0]}), "R3 R5 R6 rx word", vsample,
          m[1] ? rw : {8'h00, rw[7:0]});
    end else begin
      chk(nvalid == 0, "R8 R9 no rx word", nvalid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchecks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(oe == 0 && rvalid == 0 && rsample == 0, "R11 reset state", {oe, rvalid, rsample}, 0);
    rst_n = 1; en = 1;
    // R1: no frame sync yet, so a slot at 0 must stay silent
    run_frame(2'b10, 10'd0, 10'd0, 16'hAAAA, 16'h5555, 1'b0, -1);
    chk(oe_rec == 0 && nvalid == 0, "R1 idle before first sync", {oe_rec}, 0);
    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i][53:52], VEC[i][51:42], VEC[i][41:32], VEC[i][31:16], VEC[i][15:0], 1'b1, -1);
      check_frame(VEC[i][53:52], VEC[i][51:42], VEC[i][41:32], VEC[i][31:16], VEC[i][15:0], 1'b1);
    end
    // R9: one past the frame edge, and an upper start bit set
    run_frame(2'b10, 10'd17, 10'd25, 16'h1357, 16'h2468, 1'b1, -1);
    check_frame(2'b10, 10'd17, 10'd25, 16'h1357, 16'h2468, 1'b1);
    run_frame(2'b00, 10'h200, 10'h201, 16'h0011, 16'h0022, 1'b1, -1);
    chk(oe_rec == 0 && nvalid == 0, "R9 10-bit start beyond frame", {oe_rec}, 0);
    // R8: disabled for the whole frame
    en = 0;
    run_frame(2'b10, 10'd2, 10'd2, 16'hCAFE, 16'hBEAD, 1'b1, -1);
    check_frame(2'b10, 10'd2, 10'd2, 16'hCAFE, 16'hBEAD, 1'b0);
    // R8: disabled part way through both slots
    en = 1;
    run_frame(2'b10, 10'd4, 10'd4, 16'hFFFF, 16'h9999, 1'b1, 8);
    chk(oe_rec == 32'h0000_00F0, "R8 tx cut at disable", oe_rec, 32'h0000_00F0);
    chk(nvalid == 0, "R8 cut rx discarded", nvalid, 0);
    // re-enabled: port works again with a fresh frame
    en = 1;
    run_frame(2'b01, 10'd6, 10'd20, 16'h00E7, 16'h0018, 1'b1, -1);
    check_frame(2'b01, 10'd6, 10'd20, 16'h00E7, 16'h0018, 1'b1);
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule